// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Register

This block gathers six single-bit event sources into one byte-wide register and turns them into a single host interrupt line. The register does two jobs. A host write loads the per-source enable mask. A host read returns which enabled sources have seen a rising edge since they were last enabled. A status bit has no separate acknowledge. The host clears a bit by writing its enable bit to zero. It then writes the bit back to one if it wants further events from that source.

Each source is asynchronous to the block clock. It passes through a synchroniser chain before rising-edge detection. The host interrupt is driven by the status word as a whole. It fires when the status word leaves the all-zero state. It does not fire for each individual source.

A parameter selects the form of the interrupt output:
- In level form the line stays high for as long as any status bit is set.
- In pulse form the line gives a one-cycle pulse when the status word goes from zero to non-zero. It stays quiet until the word has been emptied again.

Top module: `edge_irq_latch`

## Requirements
- R1: After reset the enable mask and all status bits are zero, a read returns 0x00 and the interrupt output is low.
- R2: With its enable bit at 1, a 0-to-1 change on a source input sets the matching status bit (source n maps to read bit n) exactly three rising clock edges after the input changes: two synchroniser stages, then one edge-detect stage.
- R3: A set status bit stays set, whatever its source input does, for as long as no write clears its enable bit.
- R4: A write loads register bits [5:0] into the enable mask; every status bit whose written enable bit is 0 reads 0 after that clock edge, so writing 0x00 empties the whole status word.
- R5: If a rising edge would set a status bit on the same clock edge as a write that disables it, the clear wins and the bit reads 0.
- R6: A rising edge that arrives while a source is disabled is lost; enabling the source afterwards does not set its status bit.
- R7: A read returns the status in bits [5:0] and 0 in bits [7:6]; written values in bits [7:6] have no effect.
- R8: In level form (PULSE_MODE = 0) the interrupt output is high exactly while the status word is non-zero.
- R9: In pulse form (PULSE_MODE = 1) the interrupt output is high for one cycle, in the first cycle the status word is non-zero after being zero, and gives no further pulse until the word has returned to zero.
- R10: While the status word is already non-zero, edges on other enabled sources add their bits to the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 6 | Asynchronous event source inputs |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 8 | Write data: new enable mask in bits [5:0] |
| rdData | output | 8 | Read data: status in bits [5:0], zero above |
| irqOut | output | 1 | Host interrupt, level or pulse form per PULSE_MODE |

## Verification
A source change is due in the status read and in the interrupt output on the third clock edge after the input moves. A register write takes effect one edge after the strobe. In pulse form the interrupt is due only in the first cycle the status becomes non-zero, and the bench expects it low in the following cycle.

The driver applies all stimulus on falling edges. Each expected result goes into a scoreboard tagged with the cycle in which it is due. The monitor samples a few nanoseconds after each rising edge and compares only the entries due in that cycle. The clear-wins case aligns the disabling write with the edge-detect cycle by counting from the source change.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  // Strobes from the register-port control into the datapath
  typedef struct packed {
    logic loadMask;   // write of a non-empty enable mask
    logic clearAll;   // write of an all-zero enable mask
  } ctlStrobe_t;

endpackage

// File: rtl/edge_irq_dp.sv
module edge_irq_dp
  import edge_irq_pkg::*;
#(
  parameter int NUM_SRC     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  ctlStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] maskIn,
  output logic [NUM_SRC-1:0] status
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [NUM_SRC-1:0] riseDet;
  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] setVec;

  // One synchroniser chain plus a history flop per source
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[CHAIN_W-2:0], srcIn[g]};
    end

    assign riseDet[g] = chain[CHAIN_W-2] & ~chain[CHAIN_W-1];
  end

  // Only sources enabled before this edge may set a bit
  assign setVec = riseDet & enMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask  <= '0;
      statusQ <= '0;
    end else if (strobe.clearAll) begin
      enMask  <= '0;
      statusQ <= '0;
    end else if (strobe.loadMask) begin
      enMask  <= maskIn;
      statusQ <= (statusQ | setVec) & maskIn;   // disable beats set
    end else begin
      statusQ <= statusQ | setVec;
    end
  end

  assign status = statusQ;

endmodule

// File: rtl/edge_irq_ctl.sv
module edge_irq_ctl
  import edge_irq_pkg::*;
#(
  parameter int NUM_SRC    = 6,
  parameter int REG_W      = 8,
  parameter bit PULSE_MODE = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic [NUM_SRC-1:0] status,
  output ctlStrobe_t         strobe,
  output logic [NUM_SRC-1:0] maskOut,
  output logic [REG_W-1:0]   rdData,
  output logic               irqOut
);

  logic anyNow;
  logic anyPrev;

  // Write decode: only the low NUM_SRC bits carry meaning
  assign maskOut         = wrData[NUM_SRC-1:0];
  assign strobe.clearAll = wrEn && (maskOut == '0);
  assign strobe.loadMask = wrEn && (maskOut != '0);

  // Read path: status zero-extended to the register width
  assign rdData = REG_W'(status);

  assign anyNow = |status;

  always_ff @(posedge clk) begin
    if (!rstN) anyPrev <= 1'b0;
    else       anyPrev <= anyNow;
  end

  if (PULSE_MODE) begin : g_pulse
    assign irqOut = anyNow & ~anyPrev;
  end else begin : g_level
    assign irqOut = anyNow;
  end

endmodule

// File: rtl/edge_irq_latch.sv
module edge_irq_latch
  import edge_irq_pkg::*;
#(
  parameter int NUM_SRC     = 6,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit PULSE_MODE  = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  output logic               irqOut
);

  ctlStrobe_t         strobe;
  logic [NUM_SRC-1:0] maskBus;
  logic [NUM_SRC-1:0] statusBus;

  edge_irq_ctl #(
    .NUM_SRC(NUM_SRC), .REG_W(REG_W), .PULSE_MODE(PULSE_MODE)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .status(statusBus), .strobe(strobe), .maskOut(maskBus),
    .rdData(rdData), .irqOut(irqOut)
  );

  edge_irq_dp #(
    .NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .strobe(strobe),
    .maskIn(maskBus), .status(statusBus)
  );

endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
  parameter int NUM_SRC    = 6,
  parameter int REG_W      = 8,
  parameter bit PULSE_MODE = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] rdData,
  input logic             irqOut
);

  logic [NUM_SRC-1:0] st;
  assign st = rdData[NUM_SRC-1:0];

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData >> NUM_SRC) == '0); // R7

  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ((st & ~$past(wrData[NUM_SRC-1:0])) == '0)); // R5

  AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((st & $past(st)) == $past(st))); // R3

  if (PULSE_MODE) begin : g_pulse
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      irqOut |=> !irqOut); // R9
    AST_PULSE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
      irqOut |-> (st != '0)); // R9
    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
      (($past(st) == '0) && (st != '0)) |-> irqOut); // R9
  end else begin : g_level
    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
      irqOut == (st != '0)); // R8
  end

endmodule

bind edge_irq_latch edge_irq_chk #(
  .NUM_SRC(NUM_SRC), .REG_W(REG_W), .PULSE_MODE(PULSE_MODE)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .irqOut(irqOut)
);

// File: tb/edge_irq_latch_tb_top.sv
module edge_irq_latch_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] srcIn = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdLvl, rdPls;
  logic       irqLvl, irqPls;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  edge_irq_latch #(.PULSE_MODE(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdLvl), .irqOut(irqLvl));

  edge_irq_latch #(.PULSE_MODE(1'b1)) dutPulse_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdPls), .irqOut(irqPls));

  typedef struct {
    int         due;
    logic [7:0] rd;
    logic       lvl;
    logic       pls;
    string      tag;
  } expItem_t;

  expItem_t sb[$];

  // Driver side: queue an expectation d cycles from now, kept in due order
  task automatic expectIn(int d, logic [7:0] rd, logic lvl, logic pls, string tag);
    expItem_t e;
    int idx;
    e.due = cyc + d; e.rd = rd; e.lvl = lvl; e.pls = pls; e.tag = tag;
    idx = sb.size();
    for (int i = 0; i < sb.size(); i++)
      if (sb[i].due > e.due) begin idx = i; break; end
    sb.insert(idx, e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(logic [7:0] v);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s cycle %0d: actual %02h expected %02h", tag, what, cyc, act, exp);
    end
  endtask

  // Monitor: compare everything due in this cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        expItem_t e;
        e = sb.pop_front();
        cmp(e.tag, "rdLevel", rdLvl, e.rd);
        cmp(e.tag, "rdPulse", rdPls, e.rd);
        cmp(e.tag, "irqLevel", {7'b0, irqLvl}, {7'b0, e.lvl});
        cmp(e.tag, "irqPulse", {7'b0, irqPls}, {7'b0, e.pls});
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    tick(3);
    expectIn(1, 8'h00, 1'b0, 1'b0, "R1 reset");
    rstN = 1'b1;
    tick(2);
    // R1: enabling alone sets nothing
    expectIn(1, 8'h00, 1'b0, 1'b0, "R1 enable only");
    regWrite(8'h3F);
    tick(2);
    // R2 latency and R9 first pulse
    srcIn[0] = 1'b1;
    expectIn(2, 8'h00, 1'b0, 1'b0, "R2 not yet");
    expectIn(3, 8'h01, 1'b1, 1'b1, "R2 set R8 R9");
    expectIn(4, 8'h01, 1'b1, 1'b0, "R9 single pulse");
    tick(6);
    // R3: source toggles, bit stays
    srcIn[0] = 1'b0;
    expectIn(4, 8'h01, 1'b1, 1'b0, "R3 source low");
    tick(5);
    srcIn[0] = 1'b1;
    expectIn(4, 8'h01, 1'b1, 1'b0, "R3 re-edge");
    tick(6);
    // R10: second source adds, no second pulse
    srcIn[3] = 1'b1;
    expectIn(3, 8'h09, 1'b1, 1'b0, "R10 add bit R9");
    tick(6);
    // R4: disable bit0 clears it
    expectIn(1, 8'h08, 1'b1, 1'b0, "R4 clear bit0");
    regWrite(8'h3E);
    tick(3);
    expectIn(1, 8'h00, 1'b0, 1'b0, "R4 clear bit3 R8");
    regWrite(8'h36);
    tick(3);
    // R6: edge while disabled is lost
    srcIn = '0;
    tick(5);
    srcIn[0] = 1'b1;
    expectIn(3, 8'h00, 1'b0, 1'b0, "R6 disabled edge");
    tick(6);
    expectIn(1, 8'h00, 1'b0, 1'b0, "R6 re-enable");
    regWrite(8'h3F);
    expectIn(2, 8'h00, 1'b0, 1'b0, "R6 still clear");
    tick(4);
    // R9: pulse re-armed after word emptied
    srcIn[5] = 1'b1;
    expectIn(3, 8'h20, 1'b1, 1'b1, "R9 rearm");
    expectIn(4, 8'h20, 1'b1, 1'b0, "R9 rearm single");
    tick(6);
    // R7: upper bits ignored and read as zero
    expectIn(1, 8'h20, 1'b1, 1'b0, "R7 upper bits");
    regWrite(8'hFF);
    tick(3);
    // R5: disable on the same edge the bit would set
    srcIn[2] = 1'b1;
    tick(2);
    expectIn(1, 8'h20, 1'b1, 1'b0, "R5 clear wins");
    regWrite(8'h3B);
    expectIn(2, 8'h20, 1'b1, 1'b0, "R5 stays clear");
    tick(4);
    // R4: write 0x00 clears all
    expectIn(1, 8'h00, 1'b0, 1'b0, "R4 clear all");
    regWrite(8'h00);
    tick(3);
    // R2: two simultaneous edges, one pulse
    srcIn = '0;
    expectIn(1, 8'h00, 1'b0, 1'b0, "R1 re-enable");
    regWrite(8'h3F);
    tick(5);
    srcIn[1] = 1'b1;
    srcIn[4] = 1'b1;
    expectIn(3, 8'h12, 1'b1, 1'b1, "R2 two sources R9");
    expectIn(4, 8'h12, 1'b1, 1'b0, "R9 one pulse");
    tick(8);
    if (sb.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL scoreboard R1 actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule